// File: doc/BRIEF.md
# Programmable supply threshold monitor

This block watches the main supply through a sampled measurement, given as an unsigned millivolt code, and raises a registered "supply low" flag when the value drops below a threshold. Software picks the threshold with a 3-bit level code. The eight levels are evenly spaced, 100 mV apart. The flag has hysteresis: it trips 50 mV below the chosen threshold and releases 50 mV above it. The previous state of the flag decides which of the two points applies.

The flag feeds an edge-sensitive interrupt line. Single-cycle pulses mark each transition: one for the supply dropping and one for the supply recovering. A lock input freezes the level code and keeps the detector enabled until the next reset. A standby-entry strobe clears the flag and drops the enable. The current enable state and level code are brought out, so the effect of the lock is visible at the ports.

Top module: `supply_level_watch`

## Requirements
- R1: During and directly after a synchronous reset, `low_flag`, `drop_evt` and `recover_evt` are 0, `armed` is 0 and `level` is 0.
- R2: The threshold for level code k (k = 0 to 7) is 2200 + 100*k mV. `level` shows the code in use, which is the `level_sel` value registered on each clock while unlocked.
- R3: While `armed` is 1 and `low_flag` is 0, a `supply_mv` value strictly below threshold − 50 sets `low_flag` on the next clock. Values at or above threshold − 50 leave it 0.
- R4: While `armed` is 1 and `low_flag` is 1, a `supply_mv` value strictly above threshold + 50 clears `low_flag` on the next clock. Values at or below threshold + 50 keep it 1.
- R5: `armed` is the `enable_req` value registered on each clock, when there is no lock and no standby. While `armed` is 0, `low_flag` is 0 on the next clock.
- R6: A `standby_enter` pulse clears `low_flag` on the next clock. When not locked, it also clears `armed` on the next clock, whatever the value of `enable_req`.
- R7: A 1 on `lock_req` sets a lock that lasts until reset. From the next clock on, `armed` reads 1 and `level` no longer follows `level_sel`, whatever `enable_req` and `standby_enter` do.
- R8: `drop_evt` is 1 for exactly one cycle, in the cycle after `low_flag` goes from 0 to 1.
- R9: `recover_evt` is 1 for exactly one cycle, in the cycle after `low_flag` goes from 1 to 0.
- R10: A change of `level_sel` while armed is applied on the next clock. The flag is then evaluated against the new threshold on the clock after that, under the same hysteresis rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_req | input | 1 | Detector enable bit |
| level_sel | input | 3 | Threshold level code |
| lock_req | input | 1 | Sets the sticky lock |
| standby_enter | input | 1 | Standby-entry strobe |
| supply_mv | input | 12 | Sampled supply, unsigned millivolts |
| low_flag | output | 1 | Registered supply-below-threshold flag |
| drop_evt | output | 1 | One-cycle pulse after the flag rises |
| recover_evt | output | 1 | One-cycle pulse after the flag falls |
| armed | output | 1 | Effective enable state |
| level | output | 3 | Level code in use |

## Verification
The assertions check on every cycle the following:
- The trip and release decisions against the threshold computed from the `level` port.
- That the flag is forced low while disarmed and after standby.
- That both event pulses follow flag edges and last one cycle.
- That the lock keeps `armed` high and `level` steady.

Only the bench's scenarios can show the exact boundary values, where a code equal to a trip point must not change the flag. They also show the full arithmetic mapping of all eight codes to millivolts, and the ordering of a level change followed by re-evaluation. The bench gets these through descending and ascending sweeps around every threshold.

// File: rtl/supply_watch_pkg.sv
package supply_watch_pkg;
  typedef enum logic {
    ZONE_OK  = 1'b0,
    ZONE_LOW = 1'b1
  } zone_e;

  function automatic int thr_mv(input int base_mv, input int step_mv, input int code);
    return base_mv + step_mv * code;
  endfunction
endpackage

// File: rtl/svw_ctrl.sv
module svw_ctrl #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_req,
  input  logic             lock_req,
  input  logic             standby_enter,
  input  logic [LVL_W-1:0] level_sel,
  output logic             armed,
  output logic [LVL_W-1:0] level
);
  logic lock_q;
  logic lock_next;

  assign lock_next = lock_q | lock_req;

  // Sticky lock: only reset clears it.
  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= lock_next;
  end

  // Enable: forced on by the lock, dropped by standby otherwise.
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= lock_next | (enable_req & ~standby_enter);
  end

  // Level code: frozen once the lock is in place.
  always_ff @(posedge clk) begin
    if (rst)          level <= '0;
    else if (!lock_q) level <= level_sel;
  end
endmodule

// File: rtl/svw_level_map.sv
module svw_level_map #(
  parameter int LVL_W   = 3,
  parameter int MV_W    = 12,
  parameter int BASE_MV = 2200,
  parameter int STEP_MV = 100,
  parameter int HALF_MV = 50
) (
  input  logic [LVL_W-1:0] level,
  output logic [MV_W:0]    trip_mv,
  output logic [MV_W:0]    release_mv
);
  import supply_watch_pkg::*;

  localparam int NLVL = 1 << LVL_W;
  localparam int TW   = MV_W + 1;

  logic [TW-1:0] trip_tbl [NLVL];
  logic [TW-1:0] rel_tbl  [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign trip_tbl[g] = TW'(thr_mv(BASE_MV, STEP_MV, g) - HALF_MV);
    assign rel_tbl[g]  = TW'(thr_mv(BASE_MV, STEP_MV, g) + HALF_MV);
  end

  assign trip_mv    = trip_tbl[level];
  assign release_mv = rel_tbl[level];
endmodule

// File: rtl/svw_hyst.sv
module svw_hyst #(
  parameter int MV_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            armed,
  input  logic            standby_enter,
  input  logic [MV_W-1:0] supply_mv,
  input  logic [MV_W:0]   trip_mv,
  input  logic [MV_W:0]   release_mv,
  output logic            low_flag
);
  import supply_watch_pkg::*;

  zone_e         zone_q;
  zone_e         zone_d;
  logic [MV_W:0] sample;

  assign sample = {1'b0, supply_mv};

  always_comb begin
    zone_d = zone_q;
    if (standby_enter || !armed) begin
      zone_d = ZONE_OK;
    end else if (zone_q == ZONE_OK) begin
      if (sample < trip_mv) zone_d = ZONE_LOW;
    end else begin
      if (sample > release_mv) zone_d = ZONE_OK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) zone_q <= ZONE_OK;
    else     zone_q <= zone_d;
  end

  assign low_flag = (zone_q == ZONE_LOW);
endmodule

// File: rtl/svw_edge.sv
module svw_edge (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  output logic rise_evt,
  output logic fall_evt
);
  logic flag_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_d   <= 1'b0;
      rise_evt <= 1'b0;
      fall_evt <= 1'b0;
    end else begin
      flag_d   <= flag;
      rise_evt <= flag & ~flag_d;
      fall_evt <= ~flag & flag_d;
    end
  end
endmodule

// File: rtl/supply_level_watch.sv
module supply_level_watch #(
  parameter int LVL_W   = 3,
  parameter int MV_W    = 12,
  parameter int BASE_MV = 2200,
  parameter int STEP_MV = 100,
  parameter int HALF_MV = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_req,
  input  logic [LVL_W-1:0] level_sel,
  input  logic             lock_req,
  input  logic             standby_enter,
  input  logic [MV_W-1:0]  supply_mv,
  output logic             low_flag,
  output logic             drop_evt,
  output logic             recover_evt,
  output logic             armed,
  output logic [LVL_W-1:0] level
);
  logic [MV_W:0] trip_mv;
  logic [MV_W:0] release_mv;

  svw_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .enable_req    (enable_req),
    .lock_req      (lock_req),
    .standby_enter (standby_enter),
    .level_sel     (level_sel),
    .armed         (armed),
    .level         (level)
  );

  svw_level_map #(
    .LVL_W   (LVL_W),
    .MV_W    (MV_W),
    .BASE_MV (BASE_MV),
    .STEP_MV (STEP_MV),
    .HALF_MV (HALF_MV)
  ) u_map (
    .level      (level),
    .trip_mv    (trip_mv),
    .release_mv (release_mv)
  );

  svw_hyst #(.MV_W(MV_W)) u_hyst (
    .clk           (clk),
    .rst           (rst),
    .armed         (armed),
    .standby_enter (standby_enter),
    .supply_mv     (supply_mv),
    .trip_mv       (trip_mv),
    .release_mv    (release_mv),
    .low_flag      (low_flag)
  );

  svw_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .flag     (low_flag),
    .rise_evt (drop_evt),
    .fall_evt (recover_evt)
  );
endmodule

// File: rtl/supply_level_watch_chk.sv
module supply_level_watch_chk #(
  parameter int LVL_W   = 3,
  parameter int MV_W    = 12,
  parameter int BASE_MV = 2200,
  parameter int STEP_MV = 100,
  parameter int HALF_MV = 50
) (
  input logic             clk,
  input logic             rst,
  input logic             enable_req,
  input logic [LVL_W-1:0] level_sel,
  input logic             lock_req,
  input logic             standby_enter,
  input logic [MV_W-1:0]  supply_mv,
  input logic             low_flag,
  input logic             drop_evt,
  input logic             recover_evt,
  input logic             armed,
  input logic [LVL_W-1:0] level
);
  int   thr;
  logic seen_lock;

  assign thr = BASE_MV + STEP_MV * int'(level);

  always_ff @(posedge clk) begin
    if (rst) seen_lock <= 1'b0;
    else     seen_lock <= seen_lock | lock_req;
  end

  p_trip_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !standby_enter && !low_flag && int'(supply_mv) < thr - HALF_MV) |=> low_flag);

  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !standby_enter && low_flag && int'(supply_mv) > thr + HALF_MV) |=> !low_flag);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !standby_enter && low_flag && int'(supply_mv) <= thr + HALF_MV) |=> low_flag);

  p_disarmed_r5: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !low_flag);

  p_standby_r6: assert property (@(posedge clk) disable iff (rst)
    standby_enter |=> !low_flag);

  p_lock_armed_r7: assert property (@(posedge clk) disable iff (rst)
    seen_lock |-> armed);

  p_lock_level_r7: assert property (@(posedge clk) disable iff (rst)
    (seen_lock && $past(seen_lock)) |-> $stable(level));

  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(low_flag) |=> drop_evt);

  p_drop_once_r8: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> !drop_evt);

  p_recover_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(low_flag) |=> recover_evt);

  p_recover_once_r9: assert property (@(posedge clk) disable iff (rst)
    recover_evt |=> !recover_evt);

  p_evt_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(drop_evt && recover_evt));
endmodule

bind supply_level_watch supply_level_watch_chk #(
  .LVL_W   (LVL_W),
  .MV_W    (MV_W),
  .BASE_MV (BASE_MV),
  .STEP_MV (STEP_MV),
  .HALF_MV (HALF_MV)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .enable_req    (enable_req),
  .level_sel     (level_sel),
  .lock_req      (lock_req),
  .standby_enter (standby_enter),
  .supply_mv     (supply_mv),
  .low_flag      (low_flag),
  .drop_evt      (drop_evt),
  .recover_evt   (recover_evt),
  .armed         (armed),
  .level         (level)
);

// File: tb/supply_level_watch_test.sv
`timescale 1ns/1ps
module supply_level_watch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable_req = 1'b0;
  logic [2:0]  level_sel = '0;
  logic        lock_req = 1'b0;
  logic        standby_enter = 1'b0;
  logic [11:0] supply_mv = 12'd3300;
  logic        low_flag, drop_evt, recover_evt, armed;
  logic [2:0]  level;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  // expected state, from the requirements
  bit       e_lock, e_arm, e_flag, e_flag_d, e_drop, e_rec;
  bit [2:0] e_lvl;

  always #2 clk = ~clk;

  supply_level_watch uut (
    .clk(clk), .rst(rst), .enable_req(enable_req), .level_sel(level_sel),
    .lock_req(lock_req), .standby_enter(standby_enter), .supply_mv(supply_mv),
    .low_flag(low_flag), .drop_evt(drop_evt), .recover_evt(recover_evt),
    .armed(armed), .level(level)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // drive at negedge, advance model at posedge, compare at next negedge
  task automatic step(input string tag, input bit en, input bit lk, input bit sb,
                      input bit [2:0] sel, input int mv);
    int  thr;
    bit  n_flag;
    enable_req = en; lock_req = lk; standby_enter = sb; level_sel = sel;
    supply_mv = 12'(mv);
    @(posedge clk);
    thr = 2200 + 100 * int'(e_lvl);
    if (sb || !e_arm)  n_flag = 1'b0;
    else if (!e_flag)  n_flag = (mv < thr - 50);
    else               n_flag = !(mv > thr + 50);
    e_drop   = e_flag & !e_flag_d;
    e_rec    = !e_flag & e_flag_d;
    e_flag_d = e_flag;
    e_flag   = n_flag;
    e_arm    = e_lock | lk | (en & !sb);
    if (!e_lock) e_lvl = sel;
    e_lock   = e_lock | lk;
    @(negedge clk);
    check(tag,  "low_flag",    int'(low_flag),    int'(e_flag));
    check("R8", "drop_evt",    int'(drop_evt),    int'(e_drop));
    check("R9", "recover_evt", int'(recover_evt), int'(e_rec));
    check(e_lock ? "R7" : "R5", "armed", int'(armed), int'(e_arm));
    check(e_lock ? "R7" : "R2", "level", int'(level), int'(e_lvl));
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fails++; n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "low_flag", int'(low_flag), 0);
    check("R1", "drop_evt", int'(drop_evt), 0);
    check("R1", "recover_evt", int'(recover_evt), 0);
    check("R1", "armed", int'(armed), 0);
    check("R1", "level", int'(level), 0);
    rst = 1'b0;
    {e_lock, e_arm, e_flag, e_flag_d, e_drop, e_rec} = '0;
    e_lvl = '0;

    // R5: disabled detector keeps the flag low even for a low supply
    repeat (3) step("R5", 1'b0, 1'b0, 1'b0, 3'd0, 1500);

    // R2/R3/R4: sweeps around every threshold, down then up, 5 mV steps
    for (int k = 0; k < 8; k++) begin
      int t = 2200 + 100 * k;
      repeat (2) step("R2", 1'b1, 1'b0, 1'b0, 3'(k), 3300);
      for (int v = t + 70; v >= t - 70; v -= 5) step("R3", 1'b1, 1'b0, 1'b0, 3'(k), v);
      for (int v = t - 70; v <= t + 70; v += 5) step("R4", 1'b1, 1'b0, 1'b0, 3'(k), v);
      step("R3", 1'b1, 1'b0, 1'b0, 3'(k), t - 50);
      step("R3", 1'b1, 1'b0, 1'b0, 3'(k), t - 51);
      step("R4", 1'b1, 1'b0, 1'b0, 3'(k), t + 50);
      step("R4", 1'b1, 1'b0, 1'b0, 3'(k), t + 51);
    end

    // R10: level change moves the trip point
    repeat (2) step("R10", 1'b1, 1'b0, 1'b0, 3'd0, 2650);
    repeat (3) step("R10", 1'b1, 1'b0, 1'b0, 3'd7, 2650);
    repeat (3) step("R10", 1'b1, 1'b0, 1'b0, 3'd0, 2650);

    // R5: disable while low
    repeat (3) step("R5", 1'b1, 1'b0, 1'b0, 3'd7, 2000);
    repeat (3) step("R5", 1'b0, 1'b0, 1'b0, 3'd7, 2000);

    // R6: standby clears flag and enable
    repeat (3) step("R6", 1'b1, 1'b0, 1'b0, 3'd7, 2000);
    step("R6", 1'b1, 1'b0, 1'b1, 3'd7, 2000);
    repeat (3) step("R6", 1'b1, 1'b0, 1'b0, 3'd7, 2000);

    // R7: lock freezes level and keeps the detector on
    step("R7", 1'b1, 1'b1, 1'b0, 3'd3, 3300);
    step("R7", 1'b0, 1'b0, 1'b0, 3'd6, 2400);
    repeat (3) step("R7", 1'b0, 1'b0, 1'b0, 3'd1, 2400);
    step("R7", 1'b0, 1'b0, 1'b1, 3'd0, 2400);
    repeat (3) step("R7", 1'b0, 1'b0, 1'b0, 3'd0, 2400);
    repeat (2) step("R7", 1'b0, 1'b0, 1'b0, 3'd0, 2600);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule